// File: doc/BRIEF.md
# Reciprocal Frequency Counter with Synchronized Gate

This block measures the frequency of an unknown pulse train, such as the output of a voltage-to-frequency converter, by ratiometric counting. A rising edge on `convert` opens a nominal gate that lasts a programmable number of reference clocks. The real counting window is a copy of that gate that opens and closes only on rising edges of the unknown input. As a result, the window always covers a whole number of input periods.

While the window is open, one counter counts input periods and a second counter counts reference clocks. When the window closes, both counts freeze and `done` rises. The host then reads both counts and computes the frequency as the period count divided by the reference count, times the reference frequency. The period count is exact. Only the large reference count carries a one-count uncertainty.

The unknown input is asynchronous to the reference clock. It passes through a two-stage synchronizer and a rising-edge detector, and all logic runs on the reference clock. If the input stops, a programmable timeout ends the conversion so that the block cannot hang.

Top module: `recip_freq_counter`

## Requirements
- R1: After reset, `busy`, `done`, `timed_out`, both overflow flags and both counts are 0. A rising edge on `convert` while `busy` is 0 starts a conversion: `busy` is 1 and `done` is 0 at the following clock.
- R2: The nominal gate stays open for `gate_len` reference clocks (a value of 0 acts as 1). For a periodic input of period P clocks, the whole conversion ends within `gate_len`+P+4 clocks of the `convert` edge.
- R3: The counting window opens on the first synchronized input rising edge seen while the nominal gate is open. It closes on the first such edge seen after the gate has closed. For a periodic input of period P, `m_count`×P therefore lies in [`gate_len`−P+1, `gate_len`+P−1].
- R4: `n_count` counts reference clocks while the window is open. For a periodic input of period P it equals exactly `m_count`×P.
- R5: Starting a conversion clears both counts and both overflow flags, so a result never accumulates onto the previous one.
- R6: When a conversion ends, `done` rises and `busy` falls. Both counts then hold their values until the next start.
- R7: A `convert` edge that arrives while `busy` is 1 has no effect on the running conversion or on its end time.
- R8: A count that would pass the all-ones value stays at all ones and sets its own sticky overflow flag (`m_ovf` or `n_ovf`).
- R9: If no input edge arrives within `timeout_len` clocks after the nominal gate closes (0 acts as 1), the conversion ends with `done` and `timed_out` both 1. An input edge in the same clock as the expiry closes the window normally, and `timed_out` stays 0.
- R10: `timed_out` is cleared by the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| convert | input | 1 | Start strobe; acts on its rising edge |
| sig_in | input | 1 | Unknown pulse input, asynchronous |
| gate_len | input | GATE_W | Nominal gate length in reference clocks |
| timeout_len | input | TMO_W | Clocks to wait for an input edge after the gate closes |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | Result valid; cleared by the next start |
| timed_out | output | 1 | Last conversion ended by timeout |
| m_count | output | CNT_W | Whole input periods counted in the window |
| n_count | output | CNT_W | Reference clocks counted in the window |
| m_ovf | output | 1 | Period count saturated |
| n_ovf | output | 1 | Reference count saturated |

## Verification
Two events can fall in the same clock: the timeout expiring, and the input edge that should close the window. The bench sets `timeout_len` equal to the input period. It then shifts the phase of the `convert` edge against the input over every offset within one period, so that one of the offsets makes the closing edge land exactly on the last clock of the timeout. Each of these runs is judged correct only if it ends with `timed_out` low and with `n_count` equal to `m_count` times the period, which shows that the edge won.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GATE = 2'd1,
    ST_TAIL = 2'd2
  } rfc_state_e;
endpackage

// File: rtl/rfc_edge_sync.sv
module rfc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], async_in};
      last  <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~last;
endmodule

// File: rtl/rfc_sat_counter.sv
module rfc_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count,
  output logic         ovf
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  function automatic logic [W-1:0] sat_next(input logic [W-1:0] v);
    return (v == TOP) ? TOP : v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      ovf   <= 1'b0;
    end else if (clr) begin
      count <= '0;
      ovf   <= 1'b0;
    end else if (inc) begin
      count <= sat_next(count);
      if (count == TOP) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/rfc_gate_ctrl.sv
module rfc_gate_ctrl
  import rfc_pkg::*;
#(
  parameter int GATE_W = 16,
  parameter int TMO_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              sig_rise,
  input  logic [GATE_W-1:0] gate_len,
  input  logic [TMO_W-1:0]  timeout_len,
  output logic              busy,
  output logic              gate,
  output logic              sg,
  output logic              done,
  output logic              timed_out,
  output logic              abort
);
  rfc_state_e        state;
  logic [GATE_W-1:0] gate_cnt;
  logic [TMO_W-1:0]  tmo_cnt;

  function automatic logic [GATE_W-1:0] gate_load(input logic [GATE_W-1:0] l);
    return (l == '0) ? GATE_W'(1) : l;
  endfunction

  function automatic logic tmo_expired(input logic [TMO_W-1:0] c,
                                       input logic [TMO_W-1:0] lim);
    return ({1'b0, c} + (TMO_W+1)'(1)) >= {1'b0, lim};
  endfunction

  assign busy  = (state != ST_IDLE);
  assign gate  = (state == ST_GATE);
  assign abort = (state == ST_TAIL) && !sig_rise && tmo_expired(tmo_cnt, timeout_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      gate_cnt  <= '0;
      tmo_cnt   <= '0;
      sg        <= 1'b0;
      done      <= 1'b0;
      timed_out <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state     <= ST_GATE;
            gate_cnt  <= gate_load(gate_len);
            done      <= 1'b0;
            timed_out <= 1'b0;
            sg        <= 1'b0;
          end
        end
        ST_GATE: begin
          if (sig_rise) sg <= 1'b1;
          if (gate_cnt <= GATE_W'(1)) begin
            state   <= ST_TAIL;
            tmo_cnt <= '0;
          end else begin
            gate_cnt <= gate_cnt - 1'b1;
          end
        end
        ST_TAIL: begin
          if (sig_rise) begin
            sg    <= 1'b0;
            done  <= 1'b1;
            state <= ST_IDLE;
          end else if (abort) begin
            sg        <= 1'b0;
            done      <= 1'b1;
            timed_out <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            tmo_cnt <= tmo_cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/recip_freq_counter.sv
module recip_freq_counter #(
  parameter int CNT_W  = 16,
  parameter int GATE_W = 16,
  parameter int TMO_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              convert,
  input  logic              sig_in,
  input  logic [GATE_W-1:0] gate_len,
  input  logic [TMO_W-1:0]  timeout_len,
  output logic              busy,
  output logic              done,
  output logic              timed_out,
  output logic [CNT_W-1:0]  m_count,
  output logic [CNT_W-1:0]  n_count,
  output logic              m_ovf,
  output logic              n_ovf
);
  logic conv_q;
  logic start;
  logic sig_rise;
  logic gate;
  logic sg;
  logic abort;
  logic m_inc;
  logic n_inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) conv_q <= 1'b0;
    else        conv_q <= convert;
  end

  assign start = convert & ~conv_q & ~busy;
  assign m_inc = sg & sig_rise;
  assign n_inc = sg;

  rfc_edge_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(sig_in), .rise(sig_rise)
  );

  rfc_gate_ctrl #(.GATE_W(GATE_W), .TMO_W(TMO_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .sig_rise(sig_rise),
    .gate_len(gate_len), .timeout_len(timeout_len),
    .busy(busy), .gate(gate), .sg(sg), .done(done),
    .timed_out(timed_out), .abort(abort)
  );

  rfc_sat_counter #(.W(CNT_W)) u_m (
    .clk(clk), .rst_n(rst_n), .clr(start), .inc(m_inc),
    .count(m_count), .ovf(m_ovf)
  );

  rfc_sat_counter #(.W(CNT_W)) u_n (
    .clk(clk), .rst_n(rst_n), .clr(start), .inc(n_inc),
    .count(n_count), .ovf(n_ovf)
  );
endmodule

// File: rtl/recip_freq_counter_chk.sv
module recip_freq_counter_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             gate,
  input logic             sg,
  input logic             sig_rise,
  input logic             abort,
  input logic             done,
  input logic             timed_out,
  input logic [CNT_W-1:0] m_count,
  input logic [CNT_W-1:0] n_count,
  input logic             m_ovf,
  input logic             n_ovf
);
  // R7
  gate_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate) |-> $past(!busy));

  // R3
  sg_moves_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sg != $past(sg)) |-> ($past(sig_rise) || $past(abort) || $past(start)));

  // R4
  n_idle_when_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(sg)) |-> $stable(n_count));

  // R6
  frozen_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |-> ($stable(m_count) && $stable(n_count)));

  // R6
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R8
  m_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_ovf |-> (m_count == {CNT_W{1'b1}}));

  // R8
  n_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    n_ovf |-> (n_count == {CNT_W{1'b1}}));

  // R9
  timeout_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timed_out |-> done);
endmodule

bind recip_freq_counter recip_freq_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .gate(gate),
  .sg(sg), .sig_rise(sig_rise), .abort(abort), .done(done),
  .timed_out(timed_out), .m_count(m_count), .n_count(n_count),
  .m_ovf(m_ovf), .n_ovf(n_ovf)
);

// File: tb/test_recip_freq_counter.sv
module test_recip_freq_counter;
  localparam int CNT_W  = 8;
  localparam int GATE_W = 12;
  localparam int TMO_W  = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              convert = 1'b0;
  logic              sig_in = 1'b0;
  logic [GATE_W-1:0] gate_len = '0;
  logic [TMO_W-1:0]  timeout_len = '0;
  logic              busy, done, timed_out, m_ovf, n_ovf;
  logic [CNT_W-1:0]  m_count, n_count;

  int  n_tests = 0;
  int  n_fail  = 0;
  int  per     = 4;
  bit  sig_en  = 1'b1;

  always #5 clk = ~clk;

  recip_freq_counter #(.CNT_W(CNT_W), .GATE_W(GATE_W), .TMO_W(TMO_W)) i_recip_freq_counter (
    .clk(clk), .rst_n(rst_n), .convert(convert), .sig_in(sig_in),
    .gate_len(gate_len), .timeout_len(timeout_len), .busy(busy),
    .done(done), .timed_out(timed_out), .m_count(m_count),
    .n_count(n_count), .m_ovf(m_ovf), .n_ovf(n_ovf)
  );

  // periodic input, changed on falling edges
  initial begin
    int ph;
    ph = 0;
    forever begin
      @(negedge clk);
      if (ph >= per - 1) ph = 0;
      else ph = ph + 1;
      sig_in = sig_en && (ph < ((per / 2 > 0) ? per / 2 : 1));
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_conv(input int l, input int t, output int cyc);
    gate_len    = GATE_W'(l);
    timeout_len = TMO_W'(t);
    @(negedge clk); convert = 1'b1;
    @(negedge clk); convert = 1'b0;
    cyc = 1;
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic set_period(input int p);
    per = p;
    repeat (2 * p + 4) @(negedge clk);
  endtask

  // checks R3 and R4 on a finished run of a periodic input
  task automatic chk_periodic(input int l, input int p, input string tag);
    int mp;
    mp = int'(m_count) * p;
    chk(mp >= l - p + 1 && mp <= l + p - 1, {tag, " R3 m*P window"}, mp, l);
    chk(int'(n_count) == mp, {tag, " R4 n==m*P"}, int'(n_count), mp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int cyc;
    int first_m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(!busy && !done && !timed_out, "R1 reset flags", {busy, done, timed_out}, 0);
    chk(m_count == 0 && n_count == 0 && !m_ovf && !n_ovf, "R1 reset counts",
        int'(m_count) + int'(n_count), 0);

    // R1 start handshake
    set_period(4);
    gate_len = GATE_W'(30); timeout_len = TMO_W'(40);
    @(negedge clk); convert = 1'b1;
    @(negedge clk); convert = 1'b0;
    chk(busy && !done, "R1 start busy", {busy, done}, 2);
    while (!done) @(negedge clk);
    chk_periodic(30, 4, "start");

    // R2 R3 R4 R5 R6 sweep
    for (int pi = 0; pi < 5; pi++) begin
      int p;
      p = (pi == 0) ? 2 : (pi == 1) ? 3 : (pi == 2) ? 5 : (pi == 3) ? 7 : 11;
      set_period(p);
      for (int li = 0; li < 3; li++) begin
        int l;
        l = (li == 0) ? 12 : (li == 1) ? 23 : 40;
        run_conv(l, 60, cyc);
        chk(done && !busy, "R6 done at end", {done, busy}, 2);
        chk(cyc <= l + p + 4, "R2 duration", cyc, l + p + 4);
        chk(!timed_out, "R9 no timeout on live input", timed_out, 0);
        chk_periodic(l, p, "sweep R5");
        first_m = int'(m_count);
        repeat (5) @(negedge clk);
        chk(int'(m_count) == first_m, "R6 counts held", int'(m_count), first_m);
      end
    end

    // R7 convert during busy ignored
    set_period(3);
    gate_len = GATE_W'(40); timeout_len = TMO_W'(60);
    @(negedge clk); convert = 1'b1;
    @(negedge clk); convert = 1'b0;
    cyc = 1;
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (cyc == 20) convert = 1'b1;
      if (cyc == 22) convert = 1'b0;
    end
    convert = 1'b0;
    chk(cyc <= 40 + 3 + 4, "R7 ignored convert", cyc, 47);
    chk_periodic(40, 3, "R7");

    // R8 reference count saturates only
    set_period(2);
    run_conv(300, 60, cyc);
    chk(n_ovf && n_count == 8'hFF, "R8 n saturate", int'(n_count), 255);
    chk(!m_ovf && m_count == 8'd150, "R8 m exact", int'(m_count), 150);

    // R8 both saturate
    run_conv(600, 60, cyc);
    chk(m_ovf && m_count == 8'hFF, "R8 m saturate", int'(m_count), 255);
    chk(n_ovf && n_count == 8'hFF, "R8 n saturate2", int'(n_count), 255);

    // R5 overflow flags cleared by next start
    run_conv(20, 60, cyc);
    chk(!m_ovf && !n_ovf, "R5 ovf cleared", {m_ovf, n_ovf}, 0);
    chk_periodic(20, 2, "R5 after ovf");

    // R9 timeout with stopped input
    sig_en = 1'b0;
    repeat (6) @(negedge clk);
    run_conv(20, 30, cyc);
    chk(done && timed_out, "R9 timeout flag", {done, timed_out}, 3);
    chk(m_count == 0 && n_count == 0, "R9 no counts", int'(m_count) + int'(n_count), 0);
    chk(cyc >= 49 && cyc <= 53, "R9 timeout length", cyc, 50);

    // R10 timeout flag cleared by next start
    sig_en = 1'b1;
    set_period(4);
    run_conv(24, 30, cyc);
    chk(done && !timed_out, "R10 timeout cleared", timed_out, 0);
    chk_periodic(24, 4, "R10");

    // R9 edge in the expiry cycle wins: timeout equal to the period, all phases
    for (int p = 3; p <= 8; p++) begin
      set_period(p);
      for (int k = 0; k < p; k++) begin
        repeat (k) @(negedge clk);
        run_conv(20, p, cyc);
        chk(done && !timed_out, "R9 edge beats expiry", timed_out, 0);
        chk_periodic(20, p, "R9 collision");
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule